// File: doc/BRIEF.md
# Four-Track Speculative Floating-Point Status Register

This block holds the floating-point control and exception status for one primary instruction stream (track 0) and three speculative streams (tracks 1 to 3). Every track owns a control word, made up of a rounding mode, a precision setting and a mask of disabled traps, and a set of six sticky exception flags. Retiring operations name a track and OR their exception flags into that track. A clear command empties one track's flags at once. A check command tests one track for any flag that its mask does not disable.

Each track counts its own in-flight operations: the count rises on issue and falls on completion. The resulting per-track busy signal is the only interlock. A check on one track therefore never waits on work that belongs to another track. A clearing of flags never stalls. A write of control bits passes through a fixed delay pipeline before it governs new operations. Each issued operation receives the rounding and precision of its own track one cycle later.

Top module: `fpsr_tracks`

## Requirements
- R1: During and right after synchronous reset, all flags are 0, all busy bits are 0, every control word is 0 (ctl word layout: bits 1:0 rounding, bits 3:2 precision, bits 9:4 trap-disable mask), and op_vld and chk_done are 0.
- R2: A completion on track t with flag bits F makes track t's flags equal to their previous value OR F on the next edge (flag bits 0..5 = invalid, denormal, divide-by-zero, overflow, underflow, inexact; track t occupies flags_all bits 6t+5:6t). Other tracks keep their flags.
- R3: A clear on track t sets that track's flags to 0 on the next edge, even when a completion on the same track arrives in the same cycle. Flags of other tracks, including ones updated in that cycle, are kept.
- R4: A clear takes effect on the next edge whatever the busy state of the track. The busy bit is not changed by a clear.
- R5: An issue on track t makes trk_busy[t] 1 after the edge that samples it. The busy bits of other tracks do not change.
- R6: trk_busy[t] returns to 0 only once as many completions as issues have been seen on track t. An issue and a completion on the same track in one cycle leave the count unchanged.
- R7: A control write sampled at one edge shows on ctl_all (track t at bits 10t+9:10t) at the seventh edge, counting the sampling edge as the first. Before that the old word stays, and other tracks are unaffected.
- R8: One edge after an issue, op_vld is 1 and op_rnd/op_prec carry the rounding and precision in effect for the issued track at the time of issue.
- R9: One edge after chk_vld, chk_done is 1 and chk_raise is 1 exactly when the selected track has a set flag whose trap-disable mask bit (mask bit i covers flag bit i) is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | An operation issues |
| iss_trk | input | 2 | Track of the issuing operation |
| cmp_vld | input | 1 | An operation completes and reports flags |
| cmp_trk | input | 2 | Track of the completing operation |
| cmp_flags | input | 6 | Exception flags of the completing operation |
| clr_vld | input | 1 | Clear the flags of one track |
| clr_trk | input | 2 | Track to clear |
| ctl_we | input | 1 | Write a control word |
| ctl_trk | input | 2 | Track whose control word is written |
| ctl_wd | input | 10 | New control word |
| chk_vld | input | 1 | Test one track for unmasked flags |
| chk_trk | input | 2 | Track to test |
| trk_busy | output | 4 | Per-track in-flight indication |
| flags_all | output | 24 | Sticky flags of all tracks |
| ctl_all | output | 40 | Effective control words of all tracks |
| op_vld | output | 1 | Control for an issued operation is valid |
| op_rnd | output | 2 | Rounding mode for that operation |
| op_prec | output | 2 | Precision for that operation |
| chk_done | output | 1 | Check result is valid |
| chk_raise | output | 1 | Selected track holds an unmasked flag |

## Verification
Flag accumulation is tried with disjoint and overlapping bit patterns on several tracks. This tells a true sticky OR apart from an overwrite or a write to the wrong track. Clears are applied together with same-track and other-track completions and while the track is busy. These patterns separate clear priority from plain ordering and show that a clear does not depend on the interlock. In-flight tests mix issues and completions on one track while watching the others, and include a same-cycle issue and completion. Control writes are watched on every edge of the delay window, and checks are made with masked and unmasked flags, so that a delay that is off by one or a missing mask is visible.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int NF     = 6;
  localparam int RND_W  = 2;
  localparam int PREC_W = 2;
  localparam int CW     = RND_W + PREC_W + NF;
  localparam int RND_LO  = 0;
  localparam int PREC_LO = RND_W;
  localparam int MASK_LO = RND_W + PREC_W;
  localparam int FL_INV = 0;
  localparam int FL_DEN = 1;
  localparam int FL_DBZ = 2;
  localparam int FL_OVF = 3;
  localparam int FL_UNF = 4;
  localparam int FL_INX = 5;
endpackage

// File: rtl/trk_flags.sv
module trk_flags #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_vld,
  input  logic [NF-1:0] set_bits,
  input  logic          clr,
  output logic [NF-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst)          flags <= '0;
    else if (clr)     flags <= '0;
    else if (set_vld) flags <= flags | set_bits;
  end
endmodule

// File: rtl/trk_inflight.sv
module trk_inflight #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic busy
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && !dec && cnt != CMAX) cnt <= cnt + 1'b1;
    else if (dec && !inc && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ctl_delay.sv
module ctl_delay #(
  parameter int NTRK = 4,
  parameter int TW   = 2,
  parameter int CW   = 10,
  parameter int LAT  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [TW-1:0]      trk,
  input  logic [CW-1:0]      wd,
  output logic [NTRK*CW-1:0] eff_flat
);
  localparam int PD = LAT - 1;
  logic [PD-1:0] pv;
  logic [TW-1:0] pt [PD];
  logic [CW-1:0] pd [PD];

  always_ff @(posedge clk) begin
    if (rst) pv <= '0;
    else     pv <= {pv[PD-2:0], we};
  end

  always_ff @(posedge clk) begin
    pt[0] <= trk;
    pd[0] <= wd;
    for (int i = 1; i < PD; i++) begin
      pt[i] <= pt[i-1];
      pd[i] <= pd[i-1];
    end
  end

  for (genvar g = 0; g < NTRK; g++) begin : g_eff
    logic [CW-1:0] eff;
    always_ff @(posedge clk) begin
      if (rst) eff <= '0;
      else if (pv[PD-1] && pt[PD-1] == TW'(g)) eff <= pd[PD-1];
    end
    assign eff_flat[g*CW +: CW] = eff;
  end
endmodule

// File: rtl/fpsr_check.sv
module fpsr_check #(
  parameter int NTRK = 4,
  parameter int TW   = 2,
  parameter int NF   = 6,
  parameter int CW   = 10,
  parameter int MLO  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chk_vld,
  input  logic [TW-1:0]      chk_trk,
  input  logic [NTRK*NF-1:0] flags_flat,
  input  logic [NTRK*CW-1:0] ctl_flat,
  output logic               done,
  output logic               raise
);
  logic [NF-1:0] sel_fl;
  logic [NF-1:0] sel_msk;

  always_comb begin
    sel_fl  = '0;
    sel_msk = '0;
    for (int t = 0; t < NTRK; t++) begin
      if (chk_trk == TW'(t)) begin
        sel_fl  = flags_flat[t*NF +: NF];
        sel_msk = ctl_flat[t*CW + MLO +: NF];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      raise <= 1'b0;
    end else begin
      done  <= chk_vld;
      raise <= chk_vld && |(sel_fl & ~sel_msk);
    end
  end
endmodule

// File: rtl/fpsr_tracks.sv
module fpsr_tracks
  import fpsr_pkg::*;
#(
  parameter int NTRK    = 4,
  parameter int CNT_W   = 4,
  parameter int CTL_LAT = 7,
  localparam int TW     = (NTRK > 1) ? $clog2(NTRK) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                iss_vld,
  input  logic [TW-1:0]       iss_trk,
  input  logic                cmp_vld,
  input  logic [TW-1:0]       cmp_trk,
  input  logic [NF-1:0]       cmp_flags,
  input  logic                clr_vld,
  input  logic [TW-1:0]       clr_trk,
  input  logic                ctl_we,
  input  logic [TW-1:0]       ctl_trk,
  input  logic [CW-1:0]       ctl_wd,
  input  logic                chk_vld,
  input  logic [TW-1:0]       chk_trk,
  output logic [NTRK-1:0]     trk_busy,
  output logic [NTRK*NF-1:0]  flags_all,
  output logic [NTRK*CW-1:0]  ctl_all,
  output logic                op_vld,
  output logic [RND_W-1:0]    op_rnd,
  output logic [PREC_W-1:0]   op_prec,
  output logic                chk_done,
  output logic                chk_raise
);
  for (genvar g = 0; g < NTRK; g++) begin : g_trk
    trk_flags #(.NF(NF)) u_fl (
      .clk(clk), .rst(rst),
      .set_vld(cmp_vld && cmp_trk == TW'(g)),
      .set_bits(cmp_flags),
      .clr(clr_vld && clr_trk == TW'(g)),
      .flags(flags_all[g*NF +: NF])
    );
    trk_inflight #(.CNT_W(CNT_W)) u_if (
      .clk(clk), .rst(rst),
      .inc(iss_vld && iss_trk == TW'(g)),
      .dec(cmp_vld && cmp_trk == TW'(g)),
      .busy(trk_busy[g])
    );
  end

  ctl_delay #(.NTRK(NTRK), .TW(TW), .CW(CW), .LAT(CTL_LAT)) u_dly (
    .clk(clk), .rst(rst), .we(ctl_we), .trk(ctl_trk), .wd(ctl_wd),
    .eff_flat(ctl_all)
  );

  fpsr_check #(.NTRK(NTRK), .TW(TW), .NF(NF), .CW(CW), .MLO(MASK_LO)) u_chk (
    .clk(clk), .rst(rst), .chk_vld(chk_vld), .chk_trk(chk_trk),
    .flags_flat(flags_all), .ctl_flat(ctl_all),
    .done(chk_done), .raise(chk_raise)
  );

  logic [CW-1:0] iss_ctl;
  always_comb begin
    iss_ctl = '0;
    for (int t = 0; t < NTRK; t++)
      if (iss_trk == TW'(t)) iss_ctl = ctl_all[t*CW +: CW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_vld  <= 1'b0;
      op_rnd  <= '0;
      op_prec <= '0;
    end else begin
      op_vld <= iss_vld;
      if (iss_vld) begin
        op_rnd  <= iss_ctl[RND_LO +: RND_W];
        op_prec <= iss_ctl[PREC_LO +: PREC_W];
      end
    end
  end
endmodule

// File: rtl/fpsr_tracks_chk.sv
module fpsr_tracks_chk
  import fpsr_pkg::*;
#(
  parameter int NTRK = 4,
  parameter int TW   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               iss_vld,
  input logic [TW-1:0]      iss_trk,
  input logic               cmp_vld,
  input logic [TW-1:0]      cmp_trk,
  input logic               clr_vld,
  input logic [TW-1:0]      clr_trk,
  input logic               chk_vld,
  input logic [NTRK-1:0]    trk_busy,
  input logic [NTRK*NF-1:0] flags_all,
  input logic               op_vld,
  input logic               chk_done,
  input logic               chk_raise
);
  for (genvar g = 0; g < NTRK; g++) begin : g_a
    // R2
    sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
      !(clr_vld && clr_trk == TW'(g)) |=>
        ((flags_all[g*NF +: NF] & $past(flags_all[g*NF +: NF])) == $past(flags_all[g*NF +: NF])));
    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_vld && clr_trk == TW'(g)) |=> (flags_all[g*NF +: NF] == '0));
    // R5
    busy_after_issue_chk: assert property (@(posedge clk) disable iff (rst)
      (iss_vld && iss_trk == TW'(g) && !(cmp_vld && cmp_trk == TW'(g))) |=> trk_busy[g]);
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!trk_busy[g] && !(iss_vld && iss_trk == TW'(g))) |=> !trk_busy[g]);
  end
  // R8
  op_valid_chk: assert property (@(posedge clk) disable iff (rst)
    iss_vld |=> op_vld);
  // R8
  op_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !iss_vld |=> !op_vld);
  // R9
  raise_done_chk: assert property (@(posedge clk) disable iff (rst)
    chk_raise |-> chk_done);
  // R9
  check_done_chk: assert property (@(posedge clk) disable iff (rst)
    chk_vld |=> chk_done);
endmodule

bind fpsr_tracks fpsr_tracks_chk #(.NTRK(NTRK), .TW(TW)) u_fpsr_chk (.*);

// File: tb/sim_fpsr_tracks.sv
`timescale 1ns/1ps
module sim_fpsr_tracks;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_vld = 0, cmp_vld = 0, clr_vld = 0, ctl_we = 0, chk_vld = 0;
  logic [1:0] iss_trk = 0, cmp_trk = 0, clr_trk = 0, ctl_trk = 0, chk_trk = 0;
  logic [5:0] cmp_flags = 0;
  logic [9:0] ctl_wd = 0;
  logic [3:0] trk_busy;
  logic [23:0] flags_all;
  logic [39:0] ctl_all;
  logic op_vld, chk_done, chk_raise;
  logic [1:0] op_rnd, op_prec;
  int checks = 0, errors = 0;
  bit done_run = 0;

  always #2 clk = ~clk;

  fpsr_tracks u0 (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    iss_vld = 0; cmp_vld = 0; clr_vld = 0; ctl_we = 0; chk_vld = 0; cmp_flags = 0;
  endtask

  task automatic do_reset();
    idle(); rst = 1; step(); step(); rst = 0;
  endtask

  function automatic logic [5:0] fl(input int t);
    return flags_all[t*6 +: 6];
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1 flags", flags_all, 0);
    check("R1 busy", trk_busy, 0);
    check("R1 ctl", ctl_all, 0);
    check("R1 op_vld", op_vld, 0);
    check("R1 chk_done", chk_done, 0);
  endtask

  task automatic t_sticky();
    do_reset();
    cmp_vld = 1; cmp_trk = 1; cmp_flags = 6'b000001; step();
    cmp_flags = 6'b100000; step();
    cmp_flags = 6'b100001; step();
    cmp_trk = 2; cmp_flags = 6'b001000; step(); idle();
    check("R2 trk1 accumulated", fl(1), 6'b100001);
    check("R2 trk2 own bits", fl(2), 6'b001000);
    check("R2 trk0 untouched", fl(0), 0);
    check("R2 trk3 untouched", fl(3), 0);
  endtask

  task automatic t_clear();
    do_reset();
    cmp_vld = 1; cmp_trk = 1; cmp_flags = 6'b010010; step();
    cmp_trk = 2; cmp_flags = 6'b000011; step(); idle();
    clr_vld = 1; clr_trk = 1; cmp_vld = 1; cmp_trk = 1; cmp_flags = 6'b000100; step(); idle();
    check("R3 clear beats same-cycle update", fl(1), 0);
    check("R3 other track kept", fl(2), 6'b000011);
    clr_vld = 1; clr_trk = 2; cmp_vld = 1; cmp_trk = 3; cmp_flags = 6'b010000; step(); idle();
    check("R3 cleared trk2", fl(2), 0);
    check("R3 trk3 update kept", fl(3), 6'b010000);
  endtask

  task automatic t_clear_busy();
    do_reset();
    cmp_vld = 1; cmp_trk = 2; cmp_flags = 6'b111111; step(); idle();
    iss_vld = 1; iss_trk = 2; step(); step(); idle();
    check("R4 busy before clear", trk_busy[2], 1);
    clr_vld = 1; clr_trk = 2; step(); idle();
    check("R4 clear while busy", fl(2), 0);
    check("R4 busy kept", trk_busy[2], 1);
  endtask

  task automatic t_inflight();
    do_reset();
    iss_vld = 1; iss_trk = 1; step();
    check("R5 busy after first issue", trk_busy, 4'b0010);
    step(); idle();
    check("R5 other tracks idle", trk_busy, 4'b0010);
    iss_vld = 1; iss_trk = 1; cmp_vld = 1; cmp_trk = 1; step(); idle();
    check("R6 issue+complete keeps busy", trk_busy[1], 1);
    cmp_vld = 1; cmp_trk = 1; step(); idle();
    check("R6 still one in flight", trk_busy[1], 1);
    cmp_vld = 1; cmp_trk = 1; step(); idle();
    check("R6 idle after matching completes", trk_busy, 0);
    iss_vld = 1; iss_trk = 3; cmp_vld = 1; cmp_trk = 3; step(); idle();
    check("R6 same-cycle pair from idle", trk_busy, 0);
  endtask

  task automatic t_ctl();
    do_reset();
    ctl_we = 1; ctl_trk = 2; ctl_wd = 10'b000000_01_11; step(); idle();
    for (int k = 2; k <= 7; k++) begin
      if (k < 7) begin
        check($sformatf("R7 old word edge %0d", k - 1), ctl_all[29:20], 0);
        iss_vld = 1; iss_trk = 2;
        step(); idle();
        check("R8 op sees old control", {op_vld, op_prec, op_rnd}, 5'b1_00_00);
      end else begin
        check("R7 old word edge 6", ctl_all[29:20], 0);
        step();
        check("R7 new word edge 7", ctl_all[29:20], 10'b000000_01_11);
        check("R7 trk0 unaffected", ctl_all[9:0], 0);
      end
    end
    iss_vld = 1; iss_trk = 2; step(); idle();
    check("R8 op sees new control", {op_vld, op_prec, op_rnd}, 5'b1_01_11);
    iss_vld = 1; iss_trk = 0; step(); idle();
    check("R8 trk0 own control", {op_vld, op_prec, op_rnd}, 5'b1_00_00);
  endtask

  task automatic t_check();
    do_reset();
    cmp_vld = 1; cmp_trk = 3; cmp_flags = 6'b001000; step(); idle();
    chk_vld = 1; chk_trk = 3; step(); idle();
    check("R9 unmasked overflow", {chk_done, chk_raise}, 2'b11);
    chk_vld = 1; chk_trk = 0; step(); idle();
    check("R9 empty track", {chk_done, chk_raise}, 2'b10);
    step();
    check("R9 done drops", chk_done, 0);
    ctl_we = 1; ctl_trk = 3; ctl_wd = 10'b001000_00_00; step(); idle();
    for (int k = 0; k < 6; k++) step();
    chk_vld = 1; chk_trk = 3; step(); idle();
    check("R9 masked overflow", {chk_done, chk_raise}, 2'b10);
    cmp_vld = 1; cmp_trk = 3; cmp_flags = 6'b100000; step(); idle();
    chk_vld = 1; chk_trk = 3; step(); idle();
    check("R9 unmasked inexact", {chk_done, chk_raise}, 2'b11);
  endtask

  initial begin
    t_reset();
    t_sticky();
    t_clear();
    t_clear_busy();
    t_inflight();
    t_ctl();
    t_check();
    done_run = 1;
  end

  initial begin
    int cyc = 0;
    while (!done_run && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_run) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule